// File: doc/BRIEF.md
# Q31 Saturating Subtract Unit

This block is the execution slice for one instruction of a 64-bit processor datapath with a signal-processing extension. It subtracts one signed Q31 fraction from another with saturation. The instruction word can arrive in either of two 32-bit encodings: a standard one and a compact one. An input pin chooses which encoding applies. The block decodes the register fields and exposes the two source indices to the register file. It takes the two source values, computes the clamped difference, and commits a sign-extended 64-bit result and a write-enable one clock later.

On the same edge it maintains a sticky overflow bit in a control word. When the instruction word does not match the chosen encoding, or the extension is switched off, it raises a one-cycle cause strobe. In both cases it suppresses the write and the flag update. Handling the exception beyond the strobe is left to the surrounding pipeline.

Each issue is classified into one of four commit kinds, and a registered stage latches the outcome:
- OUT_IDLE: no issue.
- OUT_WRITE: a result is committed.
- OUT_RESERVED: the word does not decode.
- OUT_DSP_OFF: the word is valid but the extension is disabled.

The kind is recomputed from the inputs on every cycle, and each kind leads back to any other on the next cycle.

Top module: `q31_sat_sub_unit`

## Requirements
- R1: The result is the signed difference of bits 31:0 of the s operand minus bits 31:0 of the t operand. Bits 63:32 of both operands have no effect.
- R2: When the exact difference exceeds 2^31-1, the 32-bit result is 0x7FFFFFFF.
- R3: When the exact difference is below -2^31, the 32-bit result is 0x80000000.
- R4: The 64-bit write data is the 32-bit result with bit 31 copied into bits 63:32.
- R5: `ctl_value` carries the overflow flag at bit 20, and all its other bits read 0. A committed saturating operation sets the flag. A non-saturating one leaves it as it was, and only reset clears it.
- R6: Standard encoding (`compact_mode`=0), fields from bit 31 down:
  - bits 31:26 are 011111;
  - bits 25:21 are the s index;
  - bits 20:16 are the t index;
  - bits 15:11 are the destination index;
  - bits 10:6 are 10111;
  - bits 5:0 are 010000.
- R7: Compact encoding (`compact_mode`=1), fields from bit 31 down:
  - bits 31:26 are 000000;
  - bits 25:21 are the t index;
  - bits 20:16 are the s index;
  - bits 15:11 are the destination index;
  - bit 10 is 0;
  - bits 9:0 are 1101000101.
- R8: An issued word whose fixed fields do not match the selected encoding pulses `exc_reserved` for one cycle. It gives no write, no flag change and no `exc_dsp_off`, whatever the state of `dsp_enable`.
- R9: A matching word issued with `dsp_enable`=0 pulses `exc_dsp_off` for one cycle, with no write and no flag change.
- R10: Write-enable, write data, destination index, strobes and the flag all change on the clock edge that samples `issue_vld`=1. In a cycle that follows an edge without an issue, `dst_we` and both strobes are 0.
- R11: A synchronous reset clears the flag, the write-enable and both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_vld | input | 1 | An instruction is issued this cycle |
| compact_mode | input | 1 | 1 selects the compact encoding, 0 the standard one |
| dsp_enable | input | 1 | Signal-processing extension enabled |
| instr_word | input | 32 | Instruction word |
| src_s_val | input | 64 | Value of the s source register (minuend) |
| src_t_val | input | 64 | Value of the t source register (subtrahend) |
| src_s_idx | output | 5 | Decoded s register index (combinational) |
| src_t_idx | output | 5 | Decoded t register index (combinational) |
| dst_index | output | 5 | Registered destination register index |
| dst_data | output | 64 | Registered 64-bit write data |
| dst_we | output | 1 | Registered destination write-enable |
| ctl_value | output | 32 | Control word holding the sticky overflow flag |
| exc_reserved | output | 1 | Reserved-instruction cause strobe |
| exc_dsp_off | output | 1 | Extension-disabled cause strobe |

## Verification
The arithmetic is swept over every ordered pair from a set of operand corners in both encodings:
- zero and plus or minus one;
- both Q31 limits and their neighbours;
- plus or minus one half.

These pairs separate exact results from positive clamps and negative clamps, including the differences that land exactly on a limit. Every operand has garbage in its upper half, so a design that uses bits 63:32 is caught. A pseudo-random stream of operands and register indices checks the field order of each encoding, since the s and t positions swap between them. Corrupted opcode fields, issues with the extension off, and issues while the flag is already set check three things: that the strobes take priority correctly, that the flag is sticky, and that reset clears it.

// File: rtl/q31sub_pkg.sv
package q31sub_pkg;

    localparam int unsigned INSN_W  = 32;
    localparam int unsigned FIELD_W = 5;
    localparam int unsigned MAJOR_W = 6;
    localparam int unsigned TAIL_W  = 11;

    // Outcome of one cycle, latched by the commit stage.
    typedef enum logic [1:0] {
        OUT_IDLE     = 2'd0,
        OUT_WRITE    = 2'd1,
        OUT_RESERVED = 2'd2,
        OUT_DSP_OFF  = 2'd3
    } commit_kind_e;

    typedef struct packed {
        logic               match;
        logic [FIELD_W-1:0] s_idx;
        logic [FIELD_W-1:0] t_idx;
        logic [FIELD_W-1:0] d_idx;
    } dec_fields_t;

endpackage

// File: rtl/q31sub_enc_match.sv
module q31sub_enc_match
    import q31sub_pkg::*;
#(
    parameter logic [MAJOR_W-1:0] MAJOR = 6'b011111,
    parameter logic [TAIL_W-1:0]  TAIL  = 11'b10111010000,
    parameter int unsigned        S_LSB = 21,
    parameter int unsigned        T_LSB = 16,
    parameter int unsigned        D_LSB = 11
) (
    input  logic [INSN_W-1:0] word_i,
    output dec_fields_t       fields_o
);

    localparam int unsigned MAJOR_LSB = INSN_W - MAJOR_W;

    logic major_ok;
    logic tail_ok;

    always_comb begin
        major_ok        = (word_i[INSN_W-1:MAJOR_LSB] == MAJOR);
        tail_ok         = (word_i[TAIL_W-1:0] == TAIL);
        fields_o.match  = major_ok && tail_ok;
        fields_o.s_idx  = word_i[S_LSB +: FIELD_W];
        fields_o.t_idx  = word_i[T_LSB +: FIELD_W];
        fields_o.d_idx  = word_i[D_LSB +: FIELD_W];
    end

endmodule

// File: rtl/q31sub_decode.sv
module q31sub_decode
    import q31sub_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    input  logic              compact_i,
    output dec_fields_t       fields_o
);

    localparam int unsigned N_ENC = 2;

    dec_fields_t per_enc [N_ENC];

    // Variant 0: standard layout, variant 1: compact layout (s and t swapped).
    for (genvar g = 0; g < N_ENC; g++) begin : g_enc
        localparam logic [MAJOR_W-1:0] MAJ  = (g == 0) ? 6'b011111 : 6'b000000;
        localparam logic [TAIL_W-1:0]  TL   = (g == 0) ? 11'b10111010000 : 11'b01101000101;
        localparam int unsigned        SPOS = (g == 0) ? 21 : 16;
        localparam int unsigned        TPOS = (g == 0) ? 16 : 21;

        q31sub_enc_match #(
            .MAJOR (MAJ),
            .TAIL  (TL),
            .S_LSB (SPOS),
            .T_LSB (TPOS),
            .D_LSB (11)
        ) u_match (
            .word_i   (word_i),
            .fields_o (per_enc[g])
        );
    end

    always_comb begin
        fields_o = compact_i ? per_enc[1] : per_enc[0];
    end

endmodule

// File: rtl/q31sub_satsub.sv
module q31sub_satsub #(
    parameter int unsigned QW   = 32,
    parameter int unsigned XLEN = 64
) (
    input  logic [QW-1:0]   a_i,
    input  logic [QW-1:0]   b_i,
    output logic [XLEN-1:0] res_o,
    output logic            sat_o
);

    localparam int unsigned EXT_W = XLEN - QW;
    localparam logic [QW-1:0] Q_MAX = {1'b0, {(QW-1){1'b1}}};
    localparam logic [QW-1:0] Q_MIN = {1'b1, {(QW-1){1'b0}}};

    logic [QW:0]   wide;
    logic [QW-1:0] clamped;

    always_comb begin
        wide  = {a_i[QW-1], a_i} - {b_i[QW-1], b_i};
        sat_o = wide[QW] ^ wide[QW-1];
        if (!sat_o) begin
            clamped = wide[QW-1:0];
        end else if (wide[QW] == 1'b0) begin
            clamped = Q_MAX;
        end else begin
            clamped = Q_MIN;
        end
        res_o = {{EXT_W{clamped[QW-1]}}, clamped};
    end

endmodule

// File: rtl/q31_sat_sub_unit.sv
module q31_sat_sub_unit
    import q31sub_pkg::*;
#(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned QW       = 32,
    parameter int unsigned CTL_W    = 32,
    parameter int unsigned FLAG_BIT = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_vld,
    input  logic               compact_mode,
    input  logic               dsp_enable,
    input  logic [INSN_W-1:0]  instr_word,
    input  logic [XLEN-1:0]    src_s_val,
    input  logic [XLEN-1:0]    src_t_val,
    output logic [FIELD_W-1:0] src_s_idx,
    output logic [FIELD_W-1:0] src_t_idx,
    output logic [FIELD_W-1:0] dst_index,
    output logic [XLEN-1:0]    dst_data,
    output logic               dst_we,
    output logic [CTL_W-1:0]   ctl_value,
    output logic               exc_reserved,
    output logic               exc_dsp_off
);

    dec_fields_t  dec;
    commit_kind_e kind;
    logic [XLEN-1:0] sub_res;
    logic            sub_sat;

    logic               we_q, rsv_q, off_q, flag_q;
    logic [XLEN-1:0]    data_q;
    logic [FIELD_W-1:0] idx_q;

    logic               we_d, rsv_d, off_d, flag_d;
    logic [XLEN-1:0]    data_d;
    logic [FIELD_W-1:0] idx_d;

    // Upper operand halves take no part in the operation.
    logic unused_upper_halves;
    assign unused_upper_halves = ^{src_s_val[XLEN-1:QW], src_t_val[XLEN-1:QW]};

    q31sub_decode u_decode (
        .word_i    (instr_word),
        .compact_i (compact_mode),
        .fields_o  (dec)
    );

    q31sub_satsub #(
        .QW   (QW),
        .XLEN (XLEN)
    ) u_satsub (
        .a_i   (src_s_val[QW-1:0]),
        .b_i   (src_t_val[QW-1:0]),
        .res_o (sub_res),
        .sat_o (sub_sat)
    );

    assign src_s_idx = dec.s_idx;
    assign src_t_idx = dec.t_idx;

    // Classification: reserved takes priority over extension-disabled.
    always_comb begin
        if (!issue_vld) begin
            kind = OUT_IDLE;
        end else if (!dec.match) begin
            kind = OUT_RESERVED;
        end else if (!dsp_enable) begin
            kind = OUT_DSP_OFF;
        end else begin
            kind = OUT_WRITE;
        end
    end

    // Next values for the commit stage.
    always_comb begin
        we_d   = 1'b0;
        rsv_d  = 1'b0;
        off_d  = 1'b0;
        flag_d = flag_q;
        data_d = data_q;
        idx_d  = idx_q;
        unique case (kind)
            OUT_IDLE: begin
            end
            OUT_WRITE: begin
                we_d   = 1'b1;
                data_d = sub_res;
                idx_d  = dec.d_idx;
                flag_d = flag_q | sub_sat;
            end
            OUT_RESERVED: begin
                rsv_d = 1'b1;
            end
            OUT_DSP_OFF: begin
                off_d = 1'b1;
                idx_d = dec.d_idx;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q   <= 1'b0;
            rsv_q  <= 1'b0;
            off_q  <= 1'b0;
            flag_q <= 1'b0;
            data_q <= '0;
            idx_q  <= '0;
        end else begin
            we_q   <= we_d;
            rsv_q  <= rsv_d;
            off_q  <= off_d;
            flag_q <= flag_d;
            data_q <= data_d;
            idx_q  <= idx_d;
        end
    end

    assign dst_we       = we_q;
    assign dst_data     = data_q;
    assign dst_index    = idx_q;
    assign exc_reserved = rsv_q;
    assign exc_dsp_off  = off_q;
    assign ctl_value    = CTL_W'(flag_q) << FLAG_BIT;

    // R5: once set, the flag stays set until reset.
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ctl_value[FLAG_BIT] |=> ctl_value[FLAG_BIT]);

    // R5: the flag rises only together with a committed write.
    assert_flag_rise_on_write_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_value[FLAG_BIT]) |-> dst_we);

    // R4: committed data is sign-extended from bit 31.
    assert_sign_extended_R4: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> (dst_data[XLEN-1:QW] == {(XLEN-QW){dst_data[QW-1]}}));

    // R8/R9: a write never coincides with a cause strobe, and at most one strobe fires.
    assert_no_write_with_cause_R8: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> !(exc_reserved || exc_dsp_off));
    assert_single_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exc_reserved, exc_dsp_off}));

    // R10: outputs are quiet in a cycle whose preceding edge saw no issue.
    assert_quiet_without_issue_R10: assert property (@(posedge clk) disable iff (rst)
        !issue_vld |=> !(dst_we || exc_reserved || exc_dsp_off));

endmodule

// File: tb/q31_sat_sub_unit_bench.sv
module q31_sat_sub_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_vld = 1'b0;
    logic        compact_mode = 1'b0;
    logic        dsp_enable = 1'b1;
    logic [31:0] instr_word = '0;
    logic [63:0] src_s_val = '0;
    logic [63:0] src_t_val = '0;
    logic [4:0]  src_s_idx, src_t_idx, dst_index;
    logic [63:0] dst_data;
    logic        dst_we;
    logic [31:0] ctl_value;
    logic        exc_reserved, exc_dsp_off;

    int n_checks = 0;
    int n_errors = 0;
    bit exp_flag = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    q31_sat_sub_unit u_q31_sat_sub_unit (
        .clk (clk), .rst (rst), .issue_vld (issue_vld),
        .compact_mode (compact_mode), .dsp_enable (dsp_enable),
        .instr_word (instr_word), .src_s_val (src_s_val), .src_t_val (src_t_val),
        .src_s_idx (src_s_idx), .src_t_idx (src_t_idx), .dst_index (dst_index),
        .dst_data (dst_data), .dst_we (dst_we), .ctl_value (ctl_value),
        .exc_reserved (exc_reserved), .exc_dsp_off (exc_dsp_off)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_std(input logic [4:0] s, t, d);
        return {6'b011111, s, t, d, 5'b10111, 6'b010000};
    endfunction

    function automatic logic [31:0] enc_cmp(input logic [4:0] s, t, d);
        return {6'b000000, t, s, d, 1'b0, 10'b1101000101};
    endfunction

    // Exact arithmetic on 64-bit integers, then clamp to the Q31 range.
    function automatic logic [63:0] model(input logic [31:0] a, b, output bit sat);
        longint diff;
        logic [31:0] r;
        diff = longint'($signed(a)) - longint'($signed(b));
        sat  = 1'b0;
        if (diff > 64'sd2147483647) begin
            r = 32'h7FFF_FFFF; sat = 1'b1;
        end else if (diff < -64'sd2147483648) begin
            r = 32'h8000_0000; sat = 1'b1;
        end else begin
            r = diff[31:0];
        end
        return {{32{r[31]}}, r};
    endfunction

    task automatic run_op(input bit cmp, input bit en, input logic [31:0] word,
                          input bit exp_match, input logic [4:0] d,
                          input logic [63:0] sv, input logic [63:0] tv, input string req);
        logic [63:0] exp_data;
        bit sat;
        exp_data = model(sv[31:0], tv[31:0], sat);
        @(negedge clk);
        compact_mode = cmp; dsp_enable = en; instr_word = word;
        src_s_val = sv; src_t_val = tv; issue_vld = 1'b1;
        @(negedge clk);
        issue_vld = 1'b0;
        if (!exp_match) begin
            check(exc_reserved && !exc_dsp_off && !dst_we, "R8", "reserved strobe",
                  {61'd0, exc_reserved, exc_dsp_off, dst_we}, 64'h4);
        end else if (!en) begin
            check(exc_dsp_off && !exc_reserved && !dst_we, "R9", "disabled strobe",
                  {61'd0, exc_reserved, exc_dsp_off, dst_we}, 64'h2);
        end else begin
            if (sat) exp_flag = 1'b1;
            check(dst_we && !exc_reserved && !exc_dsp_off, "R10", "write enable",
                  {61'd0, exc_reserved, exc_dsp_off, dst_we}, 64'h1);
            check(dst_data === exp_data, req, "write data", dst_data, exp_data);
            check(dst_index === d, cmp ? "R7" : "R6", "destination index",
                  64'(dst_index), 64'(d));
        end
        check(ctl_value === (32'(exp_flag) << 20), "R5", "control word",
              64'(ctl_value), 64'(32'(exp_flag) << 20));
    endtask

    task automatic check_idle(input string req);
        @(negedge clk);
        check(!dst_we && !exc_reserved && !exc_dsp_off, req, "quiet outputs",
              {61'd0, exc_reserved, exc_dsp_off, dst_we}, 64'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] corners [9];
        logic [31:0] lfsr;
        corners = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                    32'h8000_0000, 32'h7FFF_FFFE, 32'h8000_0001, 32'h4000_0000,
                    32'hC000_0000};

        // R11: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!dst_we && !exc_reserved && !exc_dsp_off && ctl_value == 0, "R11",
              "reset state", {28'd0, ctl_value[20], exc_reserved, exc_dsp_off, dst_we, 32'd0}, 64'h0);

        // R8: corrupted opcodes with saturating operands leave flag clear; priority over disabled
        run_op(0, 1, enc_std(1, 2, 3) ^ 32'h0400_0000, 0, 3,
               64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, "R8");
        run_op(0, 0, enc_std(1, 2, 3) ^ 32'h0000_0001, 0, 3,
               64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, "R8");
        run_op(1, 1, enc_cmp(1, 2, 3) | 32'h0000_0400, 0, 3,
               64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, "R8");
        run_op(1, 1, enc_std(1, 2, 3), 0, 3, 64'h1, 64'h2, "R8");
        // R9: extension disabled, saturating operands, flag stays clear
        run_op(0, 0, enc_std(4, 5, 6), 1, 6,
               64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, "R9");
        run_op(1, 0, enc_cmp(4, 5, 6), 1, 6,
               64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, "R9");
        check_idle("R10");

        // R6/R7: index field positions
        @(negedge clk);
        compact_mode = 0; instr_word = enc_std(5'd9, 5'd22, 5'd3);
        #1 check(src_s_idx == 9 && src_t_idx == 22, "R6", "source indices",
                 {54'd0, src_s_idx, src_t_idx}, {54'd0, 5'd9, 5'd22});
        compact_mode = 1; instr_word = enc_cmp(5'd9, 5'd22, 5'd3);
        #1 check(src_s_idx == 9 && src_t_idx == 22, "R7", "source indices",
                 {54'd0, src_s_idx, src_t_idx}, {54'd0, 5'd9, 5'd22});

        // R1..R4: corner sweep in both encodings with garbage upper halves
        for (int e = 0; e < 2; e++) begin
            for (int i = 0; i < 9; i++) begin
                for (int j = 0; j < 9; j++) begin
                    logic [4:0] d;
                    d = 5'(i * 3 + j);
                    run_op(e[0], 1, e[0] ? enc_cmp(5'(i), 5'(j), d) : enc_std(5'(i), 5'(j), d),
                           1, d, {32'hDEAD_BEEF ^ 32'(i), corners[i]},
                           {32'h0BAD_F00D ^ 32'(j), corners[j]}, "R1");
                end
            end
        end
        check_idle("R10");

        // R11: reset clears sticky flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; exp_flag = 1'b0;
        check(ctl_value == 0, "R11", "flag after reset", 64'(ctl_value), 64'h0);

        // R2/R3 targeted, then sticky R5
        run_op(0, 1, enc_std(1, 2, 7), 1, 7, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007, "R1");
        run_op(0, 1, enc_std(1, 2, 8), 1, 8, 64'hFFFF_FFFF_7000_0000, 64'h0000_0000_9000_0000, "R2");
        run_op(1, 1, enc_cmp(1, 2, 9), 1, 9, 64'h0000_0000_9000_0000, 64'hFFFF_FFFF_7000_0000, "R3");
        run_op(1, 1, enc_cmp(1, 2, 10), 1, 10, 64'h0, 64'h0, "R5");
        run_op(0, 0, enc_std(1, 2, 11), 1, 11, 64'h0, 64'h0, "R5");

        // Random stream: R4 sign extension and field order
        lfsr = 32'hACE1_2461;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a, b, w;
            logic [4:0] s, t, d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr ^ 32'h5A5A_0F0F;
            s = a[4:0]; t = b[9:5]; d = a[14:10];
            w = k[0] ? enc_cmp(s, t, d) : enc_std(s, t, d);
            run_op(k[0], 1, w, 1, d, {b, a}, {a, b}, "R4");
            if (k % 16 == 0) begin
                @(negedge clk);
                compact_mode = k[0]; instr_word = w;
                #1 check(src_s_idx == s && src_t_idx == t, k[0] ? "R7" : "R6",
                         "random indices", {54'd0, src_s_idx, src_t_idx}, {54'd0, s, t});
            end
        end
        check_idle("R10");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule